// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Request-to-Send Gating

This block turns parallel characters into asynchronous serial frames on a single output line. A character arrives on a valid/ready handshake. The block accepts it only when the shifter is idle and the far end is willing to receive. The character is then sent as a start bit, the data bits least significant first, an optional parity bit and one or two stop bits. A baud-rate tick enable, made outside the block, sets the pace. Each bit is held for a fixed number of ticks.

Transmission is gated by an active-low request-to-send input. That input comes from a pin, so the block first synchronises it. The input is looked at only when a character is about to start: a frame that has begun always finishes, even if the request is withdrawn partway through. A control input can make the block treat the request as always asserted. The pin is then free for other uses.

The parity enable, parity sense and stop-bit count are control inputs that may change at any time. Their values are captured at the start of each frame, so a change made during a frame applies to the next character.

Top module: `uart_tx_rts`

## Requirements
- R1: With `cfg_ignore_rts`=0, `tx_ready` is 1 only while no frame is in progress and the synchronised `rts_n` is 0 (asserted). A character is accepted on a clock edge where both `tx_valid` and `tx_ready` are 1, and never otherwise.
- R2: With `cfg_ignore_rts`=1, the level of `rts_n` has no effect: `tx_ready` is 1 whenever no frame is in progress.
- R3: `rts_n` passes through SYNC_STAGES (default 2) flip-flops that reset to the negated level 1. A change on the pin reaches `tx_ready` after that many clock edges.
- R4: The line idles at 1. A frame is a start bit of 0, then DATA_BITS (default 8) data bits with the least significant bit first, then the stop bits at 1. The start bit appears on `tx_line` in the cycle right after the accepting edge.
- R5: With `cfg_parity_en`=1, one parity bit follows the data bits. Its value is the XOR of the data bits, inverted when `cfg_parity_odd`=1 (odd sense) and not inverted when it is 0 (even sense). With `cfg_parity_en`=0, no parity bit is sent and `cfg_parity_odd` has no effect.
- R6: `cfg_two_stop`=1 sends two stop bits and `cfg_two_stop`=0 sends one.
- R7: Each bit lasts exactly TICKS_PER_BIT (default 16) cycles in which `baud_tick` is 1. Cycles without a tick do not advance the frame.
- R8: The configuration inputs are captured at the accepting edge. Changes to them, or to `rts_n`, during a frame do not alter the frame in progress, and that frame always completes.
- R9: After reset, `tx_line` is 1, `tx_busy` is 0, and `tx_ready` is 0 unless `cfg_ignore_rts` is 1.
- R10: `tx_busy` is 1 from the cycle after the accepting edge until the last stop bit has lasted its full time, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | Baud-rate tick enable, one clock wide |
| tx_data | input | DATA_BITS | Character to send |
| tx_valid | input | 1 | Character on `tx_data` is valid |
| tx_ready | output | 1 | Block will accept a character at this edge |
| rts_n | input | 1 | Request-to-send pin, active low, asynchronous |
| cfg_ignore_rts | input | 1 | 1 treats the request as always asserted |
| cfg_parity_en | input | 1 | 1 adds a parity bit |
| cfg_parity_odd | input | 1 | 1 selects odd parity, 0 selects even |
| cfg_two_stop | input | 1 | 1 sends two stop bits, 0 sends one |
| tx_line | output | 1 | Serial output line |
| tx_busy | output | 1 | A frame is being sent |

## Verification
The bench builds the block with DATA_BITS=8 and SYNC_STAGES=2, but with TICKS_PER_BIT=4 instead of 16. The bit-time counter wrap and every frame length, from ten bits (no parity, one stop) to twelve bits (parity, two stops), can then be covered in a few thousand cycles. The bench also runs the tick enable at three different rates. With these settings it can cover request gating, the ignore override, the synchroniser delay, and configuration and request changes made in the middle of a frame.

// File: rtl/uart_tx_rts_pkg.sv
package uart_tx_rts_pkg;

    typedef enum logic {
        TXS_IDLE = 1'b0,
        TXS_SEND = 1'b1
    } tx_state_e;

    typedef struct packed {
        logic parity_en;
        logic parity_odd;
        logic two_stop;
    } frame_cfg_t;

endpackage

// File: rtl/uart_tx_rts_sync.sv
module uart_tx_rts_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = async_in;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], async_in};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/uart_tx_rts_framer.sv
module uart_tx_rts_framer
    import uart_tx_rts_pkg::*;
#(
    parameter int DATA_BITS = 8,
    localparam int FRAME_W  = DATA_BITS + 4,
    localparam int LEN_W    = $clog2(FRAME_W + 1)
) (
    input  logic [DATA_BITS-1:0] data,
    input  frame_cfg_t           cfg,
    output logic [FRAME_W-1:0]   frame,
    output logic [LEN_W-1:0]     frame_len
);
    logic par_bit;

    always_comb begin
        par_bit = (^data) ^ cfg.parity_odd;
        // stop bits and unused upper positions are all 1
        frame = '1;
        frame[0] = 1'b0;
        frame[DATA_BITS:1] = data;
        if (cfg.parity_en) frame[DATA_BITS+1] = par_bit;
        frame_len = LEN_W'(DATA_BITS + 2)
                  + LEN_W'(cfg.parity_en)
                  + LEN_W'(cfg.two_stop);
    end
endmodule

// File: rtl/uart_tx_rts_shifter.sv
module uart_tx_rts_shifter
    import uart_tx_rts_pkg::*;
#(
    parameter int FRAME_W       = 12,
    parameter int TICKS_PER_BIT = 16,
    localparam int LEN_W        = $clog2(FRAME_W + 1),
    localparam int TICK_W       = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               baud_tick,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic [LEN_W-1:0]   len_in,
    output logic               idle,
    output logic               line
);
    localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TICKS_PER_BIT - 1);

    typedef struct packed {
        tx_state_e          state;
        logic [FRAME_W-1:0] frame;
        logic [LEN_W-1:0]   bits_left;
        logic [TICK_W-1:0]  ticks;
        logic               line;
    } shift_st_t;

    shift_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.state)
            TXS_IDLE: begin
                st_d.line = 1'b1;
                if (start) begin
                    st_d.state     = TXS_SEND;
                    st_d.frame     = frame_in;
                    st_d.bits_left = len_in;
                    st_d.ticks     = '0;
                    st_d.line      = frame_in[0];
                end
            end
            TXS_SEND: begin
                if (baud_tick) begin
                    if (st_q.ticks == TICK_LAST) begin
                        st_d.ticks = '0;
                        if (st_q.bits_left == LEN_W'(1)) begin
                            st_d.state = TXS_IDLE;
                            st_d.line  = 1'b1;
                        end else begin
                            st_d.frame     = {1'b1, st_q.frame[FRAME_W-1:1]};
                            st_d.bits_left = st_q.bits_left - LEN_W'(1);
                            st_d.line      = st_q.frame[1];
                        end
                    end else begin
                        st_d.ticks = st_q.ticks + TICK_W'(1);
                    end
                end
            end
            default: st_d.state = TXS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.state     <= TXS_IDLE;
            st_q.frame     <= '1;
            st_q.bits_left <= '0;
            st_q.ticks     <= '0;
            st_q.line      <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign idle = (st_q.state == TXS_IDLE);
    assign line = st_q.line;
endmodule

// File: rtl/uart_tx_rts.sv
module uart_tx_rts
    import uart_tx_rts_pkg::*;
#(
    parameter int DATA_BITS     = 8,
    parameter int TICKS_PER_BIT = 16,
    parameter int SYNC_STAGES   = 2,
    localparam int FRAME_W      = DATA_BITS + 4,
    localparam int LEN_W        = $clog2(FRAME_W + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 baud_tick,
    input  logic [DATA_BITS-1:0] tx_data,
    input  logic                 tx_valid,
    output logic                 tx_ready,
    input  logic                 rts_n,
    input  logic                 cfg_ignore_rts,
    input  logic                 cfg_parity_en,
    input  logic                 cfg_parity_odd,
    input  logic                 cfg_two_stop,
    output logic                 tx_line,
    output logic                 tx_busy
);
    logic               rts_n_sync;
    logic               rts_ok;
    logic               shifter_idle;
    logic               start;
    frame_cfg_t         cfg_now;
    logic [FRAME_W-1:0] frame;
    logic [LEN_W-1:0]   frame_len;

    uart_tx_rts_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (rts_n),
        .sync_out (rts_n_sync)
    );

    always_comb begin
        cfg_now.parity_en  = cfg_parity_en;
        cfg_now.parity_odd = cfg_parity_odd;
        cfg_now.two_stop   = cfg_two_stop;
    end

    uart_tx_rts_framer #(
        .DATA_BITS (DATA_BITS)
    ) u_framer (
        .data      (tx_data),
        .cfg       (cfg_now),
        .frame     (frame),
        .frame_len (frame_len)
    );

    assign rts_ok   = cfg_ignore_rts | ~rts_n_sync;
    assign tx_ready = shifter_idle & rts_ok;
    assign start    = tx_valid & tx_ready;

    uart_tx_rts_shifter #(
        .FRAME_W       (FRAME_W),
        .TICKS_PER_BIT (TICKS_PER_BIT)
    ) u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .start     (start),
        .frame_in  (frame),
        .len_in    (frame_len),
        .idle      (shifter_idle),
        .line      (tx_line)
    );

    assign tx_busy = ~shifter_idle;
endmodule

// File: rtl/uart_tx_rts_chk.sv
module uart_tx_rts_chk (
    input logic clk,
    input logic rst_n,
    input logic baud_tick,
    input logic tx_valid,
    input logic tx_ready,
    input logic rts_n,
    input logic cfg_ignore_rts,
    input logic tx_line,
    input logic tx_busy
);
    // R4
    idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> tx_line);

    // R1
    ready_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> !tx_busy);

    // R4
    start_bit_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> (tx_busy && !tx_line));

    // R7
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy && !baud_tick) |=> (tx_busy && $stable(tx_line)));

    // R2
    ignore_rts_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ignore_rts && !tx_busy) |-> tx_ready);

    // R3
    rts_negated_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rts_n) && $past(rts_n, 2) && !cfg_ignore_rts) |-> !tx_ready);
endmodule

bind uart_tx_rts uart_tx_rts_chk u_chk (.*);

// File: tb/uart_tx_rts_test.sv
`timescale 1ns/1ps
module uart_tx_rts_test;
    localparam int TPB = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic       rts_n = 1'b1;
    logic       cfg_ignore_rts = 1'b0;
    logic       cfg_parity_en = 1'b0;
    logic       cfg_parity_odd = 1'b0;
    logic       cfg_two_stop = 1'b0;
    logic       tx_line;
    logic       tx_busy;

    int checks = 0;
    int failures = 0;
    string tag = "R9";
    int tick_div = 1;
    int tick_cnt = 0;
    bit done = 0;

    always #2 clk = ~clk;

    uart_tx_rts #(.DATA_BITS(8), .TICKS_PER_BIT(TPB), .SYNC_STAGES(2)) uut (.*);

    // behavioural reference
    bit m_s1 = 1, m_s2 = 1, m_busy = 0;
    int m_ticks = 0;
    bit m_bits[$];

    function automatic bit m_ready();
        return !m_busy && (cfg_ignore_rts || !m_s2);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 1; m_s2 = 1; m_busy = 0; m_ticks = 0; m_bits.delete();
        end else begin
            bit acc;
            acc = m_ready() && tx_valid;
            if (acc) begin
                m_bits.delete();
                m_bits.push_back(1'b0);
                for (int i = 0; i < 8; i++) m_bits.push_back(tx_data[i]);
                if (cfg_parity_en) m_bits.push_back((^tx_data) ^ cfg_parity_odd);
                m_bits.push_back(1'b1);
                if (cfg_two_stop) m_bits.push_back(1'b1);
                m_busy = 1; m_ticks = 0;
            end else if (m_busy && baud_tick) begin
                m_ticks++;
                if (m_ticks == TPB) begin
                    m_ticks = 0;
                    void'(m_bits.pop_front());
                    if (m_bits.size() == 0) m_busy = 0;
                end
            end
            m_s2 = m_s1; m_s1 = rts_n;
        end
    end

    task automatic check(input string t, input string what, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s got %b exp %b at %0t", t, what, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(tag, "tx_line", tx_line, m_busy ? m_bits[0] : 1'b1);
            check({"R10/", tag}, "tx_busy", tx_busy, m_busy);
            check({"R1/", tag}, "tx_ready", tx_ready, m_ready());
        end
    end

    always @(negedge clk) begin
        #1;
        tick_cnt = (tick_cnt + 1) % tick_div;
        baud_tick = (tick_cnt == 0);
    end

    task automatic send(input logic [7:0] d);
        @(negedge clk); #1;
        tx_data = d; tx_valid = 1'b1;
        #1;
        while (!tx_ready) begin @(negedge clk); #2; end
        @(negedge clk); #1;
        tx_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (tx_busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        bit saw_busy;
        repeat (4) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check("R9", "reset tx_line", tx_line, 1'b1);
        check("R9", "reset tx_busy", tx_busy, 1'b0);
        check("R9", "reset tx_ready", tx_ready, 1'b0);

        // R1 gated while rts negated
        tag = "R1";
        tx_data = 8'h3C; tx_valid = 1'b1;
        saw_busy = 0;
        repeat (40) begin @(negedge clk); if (tx_busy) saw_busy = 1; end
        check("R1", "no start while rts negated", saw_busy, 1'b0);
        tx_valid = 1'b0;

        // R3 sync delay on assert
        tag = "R3";
        @(negedge clk); #1 rts_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R3", "ready after sync", tx_ready, 1'b1);

        // R4 plain frames
        tag = "R4";
        send(8'hA5); wait_idle();
        send(8'h01); wait_idle();
        send(8'hFF); wait_idle();

        // R5 parity even and odd
        tag = "R5";
        cfg_parity_en = 1'b1;
        send(8'h07); wait_idle();
        cfg_parity_odd = 1'b1;
        send(8'h07); wait_idle();
        send(8'h00); wait_idle();
        cfg_parity_en = 1'b0;
        send(8'h96); wait_idle();
        cfg_parity_odd = 1'b0;

        // R6 two stop bits
        tag = "R6";
        cfg_two_stop = 1'b1;
        send(8'h5A); wait_idle();
        cfg_parity_en = 1'b1;
        send(8'hC3); wait_idle();
        cfg_parity_en = 1'b0; cfg_two_stop = 1'b0;

        // R7 tick rates
        tag = "R7";
        tick_div = 3;
        send(8'h81); wait_idle();
        tick_div = 2;
        send(8'h7E); wait_idle();

        // R8 changes mid-frame
        tag = "R8";
        send(8'h4D);
        repeat (10) @(negedge clk);
        #1 cfg_parity_en = 1'b1; cfg_two_stop = 1'b1; cfg_parity_odd = 1'b1; rts_n = 1'b1;
        wait_idle();
        check("R8", "idle after gated frame end", tx_busy, 1'b0);
        cfg_parity_en = 1'b0; cfg_two_stop = 1'b0; cfg_parity_odd = 1'b0;

        // R2 ignore rts
        tag = "R2";
        @(negedge clk); #1 cfg_ignore_rts = 1'b1;
        #1 check("R2", "ready with ignore set", tx_ready, 1'b1);
        send(8'hE1); wait_idle();
        rts_n = 1'b0;
        send(8'h2B); wait_idle();
        @(negedge clk); #1 rts_n = 1'b1; cfg_ignore_rts = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "ready low once ignore cleared", tx_ready, 1'b0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule